// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block is the control half of a microprogrammed processor. It holds the current 36-bit microinstruction in a register, splits it into the control fields that steer the datapath (ALU function, result-bus write enables, memory command and operand-bus source), and works out the 9-bit address of the microinstruction to fetch next. The control store is outside the block: the sequencer presents an address and receives the stored word, which it captures on the falling clock edge.

Every microinstruction carries its own successor address, so there is no micro program counter that increments. A three-bit jump field selects how that address is modified. Two condition bits OR the saved negative and zero flags into the top address bit, which gives a two-way branch to `Addr` or `Addr + 0x100`. A dispatch bit ORs the 8-bit opcode byte into the low address bits, which gives a jump to the microcode routine of a fetched instruction. The negative and zero flags are captured on the rising edge, so they stay valid after the ALU output moves on.

The address selection is an enumerated mode decoded with a unique case: `NA_PLAIN` (no jump bits set, take `Addr`), `NA_COND` (flag branch only), `NA_DISPATCH` (opcode dispatch only) and `NA_COND_DISPATCH` (both). The mode is chosen again for every microinstruction and there are no other transitions.

Top module: `mseq_sequencer`

## Requirements
- R1: While `rst_n` is low, `cs_addr` is 0x000 and all control outputs are 0.
- R2: The first falling clock edge after reset release loads the control store word at address 0x000. Its fields appear on the control outputs.
- R3: The microinstruction register loads `cs_word` only on the falling clock edge. Word bit layout: [35:27] next address, [26] dispatch, [25] branch-on-negative, [24] branch-on-zero, [23:16] `alu_ctl`, [15:7] `c_en`, [6:4] `mem_ctl`, [3:0] `b_sel`.
- R4: With bits [26:24] all 0, `cs_addr` equals the next-address field, whatever the values of `n_in`, `z_in` and `mbr_in`.
- R5: With bit [24] set, `cs_addr[8]` becomes 1 when the saved zero flag is 1. For example, next address 0x092 with zero flag 1 gives 0x192, and with zero flag 0 it gives 0x092.
- R6: With bit [25] set, `cs_addr[8]` becomes 1 when the saved negative flag is 1. Otherwise it equals bit 8 of the next-address field.
- R7: When bit 8 of the next-address field is 1, `cs_addr[8]` is 1 whatever the flags are.
- R8: With bit [26] set, `cs_addr[7:0]` is the bitwise OR of the low 8 next-address bits and `mbr_in`. Bit 8 follows R5 to R7.
- R9: `n_in` and `z_in` are sampled on the rising clock edge. A change to them between rising edges does not alter `cs_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags on rising edge, microinstruction on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_addr | output | 9 | Address of the next control store word |
| cs_word | input | 36 | Control store word read at `cs_addr` |
| n_in | input | 1 | ALU negative result |
| z_in | input | 1 | ALU zero result |
| mbr_in | input | 8 | Opcode byte used for dispatch |
| alu_ctl | output | 8 | ALU function and shift control |
| c_en | output | 9 | Result-bus register write enables |
| mem_ctl | output | 3 | Memory write, read, fetch command |
| b_sel | output | 4 | Operand-bus source select |

## Verification
`cs_addr` is due right after the rising edge that captures the flags. It is formed from the microinstruction loaded on the previous falling edge and from `mbr_in`. The control fields of the word at that address are due after the next falling edge. The driver sets the flags and opcode just after a falling edge and queues the expected address. The monitor compares `cs_addr` 2 ns after the rising edge, compares it again after the driver has inverted the flag inputs mid-phase, and compares the control fields 2 ns after the following falling edge.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int ADDR_W = 9;
    localparam int JAM_W  = 3;
    localparam int ALU_W  = 8;
    localparam int C_W    = 9;
    localparam int MEM_W  = 3;
    localparam int B_W    = 4;
    localparam int LOW_W  = ADDR_W - 1;
    localparam int WORD_W = ADDR_W + JAM_W + ALU_W + C_W + MEM_W + B_W;

    typedef struct packed {
        logic [ADDR_W-1:0] next;
        logic              jmpc;
        logic              jamn;
        logic              jamz;
        logic [ALU_W-1:0]  alu;
        logic [C_W-1:0]    c_en;
        logic [MEM_W-1:0]  mem;
        logic [B_W-1:0]    b_sel;
    } uinstr_t;

    typedef enum logic [1:0] {
        NA_PLAIN         = 2'b00,
        NA_COND          = 2'b01,
        NA_DISPATCH      = 2'b10,
        NA_COND_DISPATCH = 2'b11
    } na_mode_e;
endpackage

// File: rtl/mseq_flags.sv
module mseq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic n_in,
    input  logic z_in,
    output logic n_q,
    output logic z_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= 1'b0;
            z_q <= 1'b0;
        end else begin
            n_q <= n_in;
            z_q <= z_in;
        end
    end

    // R9: saved flags follow the inputs seen at the previous rising edge
    a_r9_flags_sampled: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (n_q == $past(n_in)) && (z_q == $past(z_in)))
        else $error("a_r9_flags_sampled");
endmodule

// File: rtl/mseq_mir.sv
module mseq_mir
    import mseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  uinstr_t word_in,
    output uinstr_t mir_q
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) mir_q <= '0;
        else        mir_q <= word_in;
    end
endmodule

// File: rtl/mseq_next_addr.sv
module mseq_next_addr
    import mseq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_fld,
    input  logic              jmpc,
    input  logic              jamn,
    input  logic              jamz,
    input  logic              n_q,
    input  logic              z_q,
    input  logic [LOW_W-1:0]  mbr,
    output logic [ADDR_W-1:0] next_addr
);
    na_mode_e         mode;
    logic             hi_bit;
    logic [LOW_W-1:0] low_or;

    always_comb begin
        mode   = na_mode_e'({jmpc, jamn | jamz});
        hi_bit = (jamz & z_q) | (jamn & n_q) | addr_fld[ADDR_W-1];
        low_or = addr_fld[LOW_W-1:0] | mbr;
        unique case (mode)
            NA_PLAIN:         next_addr = addr_fld;
            NA_COND:          next_addr = {hi_bit, addr_fld[LOW_W-1:0]};
            NA_DISPATCH:      next_addr = {addr_fld[ADDR_W-1], low_or};
            NA_COND_DISPATCH: next_addr = {hi_bit, low_or};
            default:          next_addr = addr_fld;
        endcase
    end
endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer
    import mseq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [ADDR_W-1:0]         cs_addr,
    input  logic [WORD_W-1:0]         cs_word,
    input  logic                      n_in,
    input  logic                      z_in,
    input  logic [LOW_W-1:0]          mbr_in,
    output logic [ALU_W-1:0]          alu_ctl,
    output logic [C_W-1:0]            c_en,
    output logic [MEM_W-1:0]          mem_ctl,
    output logic [B_W-1:0]            b_sel
);
    uinstr_t word_s;
    uinstr_t mir;
    logic    n_q;
    logic    z_q;

    assign word_s = uinstr_t'(cs_word);

    mseq_mir i_mir (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_in (word_s),
        .mir_q   (mir)
    );

    mseq_flags i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .n_in  (n_in),
        .z_in  (z_in),
        .n_q   (n_q),
        .z_q   (z_q)
    );

    mseq_next_addr i_next (
        .addr_fld  (mir.next),
        .jmpc      (mir.jmpc),
        .jamn      (mir.jamn),
        .jamz      (mir.jamz),
        .n_q       (n_q),
        .z_q       (z_q),
        .mbr       (mbr_in),
        .next_addr (cs_addr)
    );

    always_comb begin
        alu_ctl = mir.alu;
        c_en    = mir.c_en;
        mem_ctl = mir.mem;
        b_sel   = mir.b_sel;
    end

    // R1: address held at zero while reset is asserted
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_addr: assert (cs_addr == '0)
                else $error("a_r1_reset_addr");
        end
    end

    // R4: no jump bits leaves the successor field untouched
    a_r4_plain_successor: assert property (@(negedge clk) disable iff (!rst_n)
        (!mir.jmpc && !mir.jamn && !mir.jamz) |-> (cs_addr == mir.next))
        else $error("a_r4_plain_successor");

    // R7: a set top bit in the successor field is never cleared
    a_r7_high_kept: assert property (@(negedge clk) disable iff (!rst_n)
        mir.next[ADDR_W-1] |-> cs_addr[ADDR_W-1])
        else $error("a_r7_high_kept");

    // R8: every opcode bit shows up in the low address on dispatch
    a_r8_dispatch_bits: assert property (@(negedge clk) disable iff (!rst_n)
        mir.jmpc |-> ((cs_addr[LOW_W-1:0] & mbr_in) == mbr_in))
        else $error("a_r8_dispatch_bits");

    // R5: zero branch sets the top bit
    a_r5_zero_branch: assert property (@(negedge clk) disable iff (!rst_n)
        (mir.jamz && z_q) |-> cs_addr[ADDR_W-1])
        else $error("a_r5_zero_branch");
endmodule

// File: tb/test_mseq_sequencer.sv
module test_mseq_sequencer;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [8:0] mpc;
        string      tag;
    } exp_t;

    logic        clk;
    logic        rst_n;
    logic [8:0]  cs_addr;
    logic [35:0] cs_word;
    logic        n_in;
    logic        z_in;
    logic [7:0]  mbr_in;
    logic [7:0]  alu_ctl;
    logic [8:0]  c_en;
    logic [2:0]  mem_ctl;
    logic [3:0]  b_sel;

    logic [35:0] store [512];
    exp_t        q[$];
    logic [35:0] cur_word;
    int          n_tests;
    int          n_fail;
    bit          done;

    mseq_sequencer i_mseq_sequencer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_addr (cs_addr),
        .cs_word (cs_word),
        .n_in    (n_in),
        .z_in    (z_in),
        .mbr_in  (mbr_in),
        .alu_ctl (alu_ctl),
        .c_en    (c_en),
        .mem_ctl (mem_ctl),
        .b_sel   (b_sel)
    );

    assign cs_word = store[cs_addr];

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [35:0] mk(input logic [8:0] self, input logic [8:0] nxt,
                                       input logic [2:0] jam);
        return {nxt, jam, self[7:0] ^ 8'h5A, ~self, self[2:0], self[3:0] ^ 4'h9};
    endfunction

    function automatic logic [8:0] model_next(input logic [35:0] w, input logic n,
                                              input logic z, input logic [7:0] mbr);
        logic       hi;
        logic [7:0] lo;
        hi = (w[24] & z) | (w[25] & n) | w[35];
        lo = w[26] ? (w[34:27] | mbr) : w[34:27];
        return {hi, lo};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_fields(input logic [35:0] w, input string req);
        logic [23:0] act_f;
        act_f = {alu_ctl, c_en, mem_ctl, b_sel};
        check(act_f == w[23:0], req, "control fields", {12'h0, act_f}, {12'h0, w[23:0]});
    endtask

    // Driver: called just after a falling edge; leaves just after the next one
    task automatic step(input logic n, input logic z, input logic [7:0] mbr, input string tag);
        exp_t e;
        n_in   = n;
        z_in   = z;
        mbr_in = mbr;
        e.mpc  = model_next(cur_word, n, z, mbr);
        e.tag  = tag;
        q.push_back(e);
        cur_word = store[e.mpc];
        @(posedge clk);
        #3;
        n_in = ~n;          // R9: mid-phase flag change
        z_in = ~z;
        @(negedge clk);
        #1;
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                #2;
                check(cs_addr == e.mpc, e.tag, "cs_addr", {27'h0, cs_addr}, {27'h0, e.mpc});
                #2;
                check(cs_addr == e.mpc, "R9", "cs_addr after flag change",
                      {27'h0, cs_addr}, {27'h0, e.mpc});
                @(negedge clk);
                #2;
                check_fields(store[e.mpc], "R3");
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        n_tests = 0;
        n_fail  = 0;
        done    = 1'b0;
        for (int i = 0; i < 512; i++) store[i] = '0;
        store[9'h000] = mk(9'h000, 9'h092, 3'b001);
        store[9'h192] = mk(9'h192, 9'h092, 3'b001);
        store[9'h092] = mk(9'h092, 9'h050, 3'b010);
        store[9'h150] = mk(9'h150, 9'h050, 3'b010);
        store[9'h050] = mk(9'h050, 9'h033, 3'b000);
        store[9'h033] = mk(9'h033, 9'h000, 3'b100);
        store[9'h010] = mk(9'h010, 9'h100, 3'b100);
        store[9'h12A] = mk(9'h12A, 9'h1C5, 3'b011);
        store[9'h1C5] = mk(9'h1C5, 9'h005, 3'b100);
        store[9'h0A5] = mk(9'h0A5, 9'h000, 3'b101);
        store[9'h17F] = mk(9'h17F, 9'h1FF, 3'b000);
        store[9'h1FF] = mk(9'h1FF, 9'h000, 3'b000);

        n_in = 1'b1; z_in = 1'b1; mbr_in = 8'hFF;
        rst_n = 1'b1;
        #1 rst_n = 1'b0;
        #16;
        check(cs_addr == 9'h000, "R1", "cs_addr in reset", {27'h0, cs_addr}, 36'h0);
        check({alu_ctl, c_en, mem_ctl, b_sel} == 24'h0, "R1", "fields in reset",
              {12'h0, alu_ctl, c_en, mem_ctl, b_sel}, 36'h0);
        @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        #1;
        cur_word = store[9'h000];
        check_fields(store[9'h000], "R2");

        step(1'b0, 1'b1, 8'h00, "R5");   // 0x092 -> 0x192
        step(1'b1, 1'b0, 8'h00, "R5");   // zero clear -> 0x092
        step(1'b1, 1'b0, 8'h00, "R6");   // 0x050 -> 0x150
        step(1'b0, 1'b1, 8'h00, "R6");   // negative clear -> 0x050
        step(1'b1, 1'b1, 8'hFF, "R4");   // plain -> 0x033
        step(1'b0, 1'b0, 8'h10, "R8");   // dispatch -> 0x010
        step(1'b0, 1'b0, 8'h2A, "R8");   // 0x100 | 0x2A -> 0x12A
        step(1'b0, 1'b0, 8'h00, "R7");   // top bit kept -> 0x1C5
        step(1'b1, 1'b1, 8'hA0, "R8");   // 0x05 | 0xA0 -> 0x0A5
        step(1'b0, 1'b1, 8'h7F, "R5");   // both -> 0x17F
        step(1'b0, 1'b0, 8'h00, "R4");   // plain -> 0x1FF
        step(1'b1, 1'b1, 8'h00, "R4");   // plain -> 0x000
        step(1'b0, 1'b1, 8'h00, "R5");   // 0x192 again
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule